// File: doc/BRIEF.md
# Register Window Controller

This block manages the window state of a windowed integer register file. It keeps the current window pointer and the invalid-window mask, and turns a 5-bit architectural register number into a row address of a physical array of 16 × 32 + 8 rows. It also performs the pointer moves and mask rotations that go with saving and restoring a window. The number of windows is programmed at run time to any value from 3 to 32. Because that value need not be a power of two, every wrap is a compare followed by an add or a subtract. The 8 extra rows at the top of the array serve the wrap from the last window back to window 0.

Software or a sequencer pulses save, restore or flush strobes and reads back the pointer, the mask and the trap flags. It can also write the pointer in two ways: directly, or through an inverted view in which window k reads as count − 1 − k. Two window-number outputs name the window that a spill handler must write out and the window that a fill handler must reload. A third output counts how many windows a flush would spill.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset, the pointer is 0, the mask is 0, the window count is `DEF_WIN` (8), both flags are 0 and the mirrored pointer reads 7.
- R2: A configuration write with a count from 3 to 32 is taken on the next edge and also clears the pointer and the mask. A count outside that range changes nothing.
- R3: The lookup output is combinational and equals (idx + 16·cwp) mod (16·count).
- R4: When the R3 result is below 8 and the pointer equals count − 1, the lookup adds 16·count, so the row lands in the overhang.
- R5: A save whose target window (pointer − 1, with 0 wrapping to count − 1) has mask bit 0 moves the pointer to that target on the next edge.
- R6: A save whose target mask bit is 1 raises `ovf` for one cycle and leaves the pointer unchanged. The mask rotates right by one inside count bits, so bit 0 moves to bit count − 1.
- R7: A restore whose target window (pointer + 1, with count wrapping to 0) has mask bit 0 moves the pointer to that target.
- R8: A restore whose target mask bit is 1 raises `unf` for one cycle and leaves the pointer unchanged. The mask rotates left by one inside count bits, so bit count − 1 moves to bit 0.
- R9: A flush sets the mask to a single 1 at pointer + 1 (wrapped) and keeps the pointer. `flush_depth` counts the windows pointer+1, pointer+2, … (wrapped) that come before the first one with its mask bit set, and is at most count − 1.
- R10: `cwp_mirror` reads count − 1 − pointer. A mirrored write sets the pointer to count − 1 − v, and any v ≥ count is first replaced by 0.
- R11: A direct pointer write of a value ≥ count is ignored. A mask write keeps only bits 0 to count − 1.
- R12: When several requests arrive in the same cycle, only the first of this order acts: configuration, flush, save, restore, mirrored write, pointer write, mask write.
- R13: `spill_win` is pointer − 2 and `fill_win` is pointer + 1, both wrapped within count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window count write strobe |
| cfg_nwin | input | 6 | New window count |
| nwin_o | output | 6 | Current window count |
| lk_idx | input | 5 | Architectural register number |
| lk_phys | output | 10 | Physical row for lk_idx |
| save_req | input | 1 | Save step strobe |
| restore_req | input | 1 | Restore step strobe |
| flush_req | input | 1 | Flush strobe |
| cwp_we | input | 1 | Direct pointer write strobe |
| cwp_wdata | input | 5 | Direct pointer value |
| mir_we | input | 1 | Mirrored pointer write strobe |
| mir_wdata | input | 5 | Mirrored pointer value |
| wim_we | input | 1 | Mask write strobe |
| wim_wdata | input | 32 | Mask value |
| cwp_o | output | 5 | Current window pointer |
| cwp_mirror | output | 5 | Inverted pointer view |
| wim_o | output | 32 | Invalid-window mask |
| spill_win | output | 5 | Window a spill handler writes out |
| fill_win | output | 5 | Window a fill handler reloads |
| flush_depth | output | 5 | Windows a flush would spill |
| ovf | output | 1 | Save hit an invalid window |
| unf | output | 1 | Restore hit an invalid window |

## Verification
The lookup is tried with window counts of 3, 5, 6, 8 and 32, with pointers both in middle windows and in the last window, and with indices from every 8-register group. The non-power-of-two counts expose any wrap done with a bit mask, and the last-window cases with low results tell the overhang apart from a plain modulo. Save and restore are tried with the mask bit set on the target window and elsewhere, and with mask bits at bit 0 and at bit count − 1. These cases separate a trap from a move, and a rotation that wraps inside count bits from one that wraps inside 32. Simultaneous strobes and out-of-range writes check the priority order and the writes that must be ignored.

// File: rtl/wr_pkg.sv
package wr_pkg;
    localparam int MAX_WIN      = 32;
    localparam int MIN_WIN      = 3;
    localparam int REGS_PER_WIN = 16;
    localparam int OVERHANG     = 8;
    localparam int AW           = 5;
    localparam int CW           = $clog2(MAX_WIN);
    localparam int NW           = $clog2(MAX_WIN + 1);
    localparam int PW           = $clog2(REGS_PER_WIN * MAX_WIN + OVERHANG);

    typedef logic [CW-1:0]      win_t;
    typedef logic [NW-1:0]      cnt_t;
    typedef logic [NW:0]        wide_t;
    typedef logic [MAX_WIN-1:0] mask_t;
    typedef logic [PW-1:0]      phys_t;
    typedef logic [AW-1:0]      arch_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_FLUSH, OP_SAVE, OP_RESTORE, OP_MIRROR, OP_CWP, OP_WIM
    } op_e;

    typedef struct packed {
        win_t  cwp;
        mask_t wim;
        logic  ovf;
        logic  unf;
    } state_t;

    // step one window up, wrapping at the run-time count
    function automatic win_t win_inc(win_t w, cnt_t n);
        wide_t s;
        s = wide_t'(w) + wide_t'(1);
        if (s >= wide_t'(n)) s = s - wide_t'(n);
        return win_t'(s);
    endfunction

    // step one window down, wrapping below zero
    function automatic win_t win_dec(win_t w, cnt_t n);
        if (w == '0) return win_t'(n - cnt_t'(1));
        return w - win_t'(1);
    endfunction

    function automatic mask_t win_mask(cnt_t n);
        mask_t m;
        for (int i = 0; i < MAX_WIN; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    function automatic mask_t rot_right(mask_t w, cnt_t n);
        mask_t r;
        r = (w >> 1) | (w << (n - cnt_t'(1)));
        return r & win_mask(n);
    endfunction

    function automatic mask_t rot_left(mask_t w, cnt_t n);
        mask_t r;
        r = (w << 1) | (w >> (n - cnt_t'(1)));
        return r & win_mask(n);
    endfunction

    function automatic mask_t win_onehot(win_t w);
        return mask_t'(1) << w;
    endfunction
endpackage

// File: rtl/wr_map.sv
module wr_map
    import wr_pkg::*;
(
    input  win_t  cwp,
    input  cnt_t  nwin,
    input  arch_t idx,
    output phys_t phys
);
    typedef logic [PW:0] acc_t;

    acc_t span;
    acc_t sum;

    always_comb begin
        span = acc_t'(nwin) * acc_t'(REGS_PER_WIN);
        sum  = acc_t'(idx) + acc_t'(cwp) * acc_t'(REGS_PER_WIN);
        // one subtract suffices: idx < 32 keeps the sum below twice the span
        if (sum >= span) sum = sum - span;
        if (sum < acc_t'(OVERHANG) && cwp == win_t'(nwin - cnt_t'(1)))
            sum = sum + span;
        phys = phys_t'(sum);
    end
endmodule

// File: rtl/wr_flush.sv
module wr_flush
    import wr_pkg::*;
(
    input  win_t  cwp,
    input  cnt_t  nwin,
    input  mask_t wim,
    output win_t  depth
);
    wide_t pos;
    logic  hit;

    always_comb begin
        depth = '0;
        hit   = 1'b0;
        pos   = '0;
        for (int k = 1; k < MAX_WIN; k++) begin
            pos = wide_t'(cwp) + wide_t'(k);
            if (pos >= wide_t'(nwin)) pos = pos - wide_t'(nwin);
            if (!hit && k < int'(nwin)) begin
                if (wim[pos[CW-1:0]]) hit = 1'b1;
                else                  depth = depth + win_t'(1);
            end
        end
    end
endmodule

// File: rtl/wr_ctrl.sv
module wr_ctrl
    import wr_pkg::*;
#(
    parameter int DEF_WIN = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_we,
    input  cnt_t   cfg_nwin,
    input  logic   save_req,
    input  logic   restore_req,
    input  logic   flush_req,
    input  logic   cwp_we,
    input  win_t   cwp_wdata,
    input  logic   mir_we,
    input  win_t   mir_wdata,
    input  logic   wim_we,
    input  mask_t  wim_wdata,
    output state_t st,
    output cnt_t   nwin
);
    localparam cnt_t DEF_N = cnt_t'(DEF_WIN);

    op_e    op;
    state_t st_n;
    cnt_t   nwin_n;
    logic   cfg_ok;
    win_t   dn, up, mir_v;

    always_comb begin
        if      (flush_req)   op = OP_FLUSH;
        else if (save_req)    op = OP_SAVE;
        else if (restore_req) op = OP_RESTORE;
        else if (mir_we)      op = OP_MIRROR;
        else if (cwp_we)      op = OP_CWP;
        else if (wim_we)      op = OP_WIM;
        else                  op = OP_NONE;
    end

    always_comb begin
        cfg_ok = cfg_we && cfg_nwin >= cnt_t'(MIN_WIN) && cfg_nwin <= cnt_t'(MAX_WIN);
        dn     = win_dec(st.cwp, nwin);
        up     = win_inc(st.cwp, nwin);
        mir_v  = (cnt_t'(mir_wdata) >= nwin) ? '0 : mir_wdata;
        st_n     = st;
        st_n.ovf = 1'b0;
        st_n.unf = 1'b0;
        nwin_n   = nwin;
        if (cfg_ok) begin
            nwin_n   = cfg_nwin;
            st_n.cwp = '0;
            st_n.wim = '0;
        end else begin
            case (op)
                OP_FLUSH:   st_n.wim = win_onehot(up);
                OP_SAVE: begin
                    if (st.wim[dn]) begin
                        st_n.ovf = 1'b1;
                        st_n.wim = rot_right(st.wim, nwin);
                    end else begin
                        st_n.cwp = dn;
                    end
                end
                OP_RESTORE: begin
                    if (st.wim[up]) begin
                        st_n.unf = 1'b1;
                        st_n.wim = rot_left(st.wim, nwin);
                    end else begin
                        st_n.cwp = up;
                    end
                end
                OP_MIRROR:  st_n.cwp = win_t'(nwin - cnt_t'(1) - cnt_t'(mir_v));
                OP_CWP:     if (cnt_t'(cwp_wdata) < nwin) st_n.cwp = cwp_wdata;
                OP_WIM:     st_n.wim = wim_wdata & win_mask(nwin);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            nwin <= DEF_N;
        end else begin
            st   <= st_n;
            nwin <= nwin_n;
        end
    end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import wr_pkg::*;
#(
    parameter int DEF_WIN = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [NW-1:0]      cfg_nwin,
    output logic [NW-1:0]      nwin_o,
    input  logic [AW-1:0]      lk_idx,
    output logic [PW-1:0]      lk_phys,
    input  logic               save_req,
    input  logic               restore_req,
    input  logic               flush_req,
    input  logic               cwp_we,
    input  logic [CW-1:0]      cwp_wdata,
    input  logic               mir_we,
    input  logic [CW-1:0]      mir_wdata,
    input  logic               wim_we,
    input  logic [MAX_WIN-1:0] wim_wdata,
    output logic [CW-1:0]      cwp_o,
    output logic [CW-1:0]      cwp_mirror,
    output logic [MAX_WIN-1:0] wim_o,
    output logic [CW-1:0]      spill_win,
    output logic [CW-1:0]      fill_win,
    output logic [CW-1:0]      flush_depth,
    output logic               ovf,
    output logic               unf
);
    state_t st;
    cnt_t   nwin;

    wr_ctrl #(.DEF_WIN(DEF_WIN)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_nwin   (cfg_nwin),
        .save_req   (save_req),
        .restore_req(restore_req),
        .flush_req  (flush_req),
        .cwp_we     (cwp_we),
        .cwp_wdata  (cwp_wdata),
        .mir_we     (mir_we),
        .mir_wdata  (mir_wdata),
        .wim_we     (wim_we),
        .wim_wdata  (wim_wdata),
        .st         (st),
        .nwin       (nwin)
    );

    wr_map u_map (
        .cwp  (st.cwp),
        .nwin (nwin),
        .idx  (lk_idx),
        .phys (lk_phys)
    );

    wr_flush u_flush (
        .cwp   (st.cwp),
        .nwin  (nwin),
        .wim   (st.wim),
        .depth (flush_depth)
    );

    assign nwin_o     = nwin;
    assign cwp_o      = st.cwp;
    assign wim_o      = st.wim;
    assign ovf        = st.ovf;
    assign unf        = st.unf;
    assign cwp_mirror = win_t'(nwin - cnt_t'(1) - cnt_t'(st.cwp));
    assign spill_win  = win_dec(win_dec(st.cwp, nwin), nwin);
    assign fill_win   = win_inc(st.cwp, nwin);
endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk
    import wr_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_we,
    input cnt_t  cfg_nwin,
    input logic  save_req,
    input logic  restore_req,
    input logic  flush_req,
    input cnt_t  nwin_o,
    input phys_t lk_phys,
    input win_t  cwp_o,
    input win_t  cwp_mirror,
    input mask_t wim_o,
    input logic  ovf,
    input logic  unf
);
    logic cfg_hit;
    assign cfg_hit = cfg_we && cfg_nwin >= cnt_t'(MIN_WIN) && cfg_nwin <= cnt_t'(MAX_WIN);

    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        nwin_o >= cnt_t'(MIN_WIN) && nwin_o <= cnt_t'(MAX_WIN));

    p_row_bound_r4: assert property (@(posedge clk) disable iff (rst)
        11'(lk_phys) < 11'(nwin_o) * 11'(REGS_PER_WIN) + 11'(OVERHANG));

    p_save_step_r5: assert property (@(posedge clk) disable iff (rst)
        save_req && !flush_req && !cfg_hit |=>
            ovf || cwp_o == win_dec($past(cwp_o), $past(nwin_o)));

    p_ovf_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ovf |-> cwp_o == $past(cwp_o));

    p_restore_step_r7: assert property (@(posedge clk) disable iff (rst)
        restore_req && !save_req && !flush_req && !cfg_hit |=>
            unf || cwp_o == win_inc($past(cwp_o), $past(nwin_o)));

    p_unf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        unf |-> cwp_o == $past(cwp_o));

    p_flush_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        flush_req && !cfg_hit |=> $countones(wim_o) == 1);

    p_mirror_sum_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_t'(cwp_mirror) + cnt_t'(cwp_o) + cnt_t'(1) == nwin_o);

    p_wim_width_r11: assert property (@(posedge clk) disable iff (rst)
        (wim_o >> nwin_o) == '0);

    p_ptr_range_r11: assert property (@(posedge clk) disable iff (rst)
        cnt_t'(cwp_o) < nwin_o);

    p_flags_apart_r12: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));
endmodule

bind regwin_ctrl regwin_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_nwin   (cfg_nwin),
    .save_req   (save_req),
    .restore_req(restore_req),
    .flush_req  (flush_req),
    .nwin_o     (nwin_o),
    .lk_phys    (lk_phys),
    .cwp_o      (cwp_o),
    .cwp_mirror (cwp_mirror),
    .wim_o      (wim_o),
    .ovf        (ovf),
    .unf        (unf)
);

// File: tb/test_regwin_ctrl.sv
module test_regwin_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_nwin = '0;
    logic [5:0]  nwin_o;
    logic [4:0]  lk_idx = '0;
    logic [9:0]  lk_phys;
    logic        save_req = 1'b0, restore_req = 1'b0, flush_req = 1'b0;
    logic        cwp_we = 1'b0, mir_we = 1'b0, wim_we = 1'b0;
    logic [4:0]  cwp_wdata = '0, mir_wdata = '0;
    logic [31:0] wim_wdata = '0;
    logic [4:0]  cwp_o, cwp_mirror, spill_win, fill_win, flush_depth;
    logic [31:0] wim_o;
    logic        ovf, unf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    regwin_ctrl i_regwin_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_nwin(cfg_nwin), .nwin_o(nwin_o),
        .lk_idx(lk_idx), .lk_phys(lk_phys), .save_req(save_req),
        .restore_req(restore_req), .flush_req(flush_req), .cwp_we(cwp_we),
        .cwp_wdata(cwp_wdata), .mir_we(mir_we), .mir_wdata(mir_wdata),
        .wim_we(wim_we), .wim_wdata(wim_wdata), .cwp_o(cwp_o),
        .cwp_mirror(cwp_mirror), .wim_o(wim_o), .spill_win(spill_win),
        .fill_win(fill_win), .flush_depth(flush_depth), .ovf(ovf), .unf(unf)
    );

    // {count[5:0], cwp[4:0], idx[4:0], 6'b0, expected row[9:0]}
    localparam logic [31:0] VEC [11] = '{
        {6'd8,  5'd0,  5'd5,  6'd0, 10'd5},
        {6'd8,  5'd3,  5'd20, 6'd0, 10'd68},
        {6'd8,  5'd7,  5'd3,  6'd0, 10'd115},
        {6'd8,  5'd7,  5'd17, 6'd0, 10'd129},
        {6'd8,  5'd7,  5'd26, 6'd0, 10'd10},
        {6'd5,  5'd4,  5'd16, 6'd0, 10'd80},
        {6'd5,  5'd2,  5'd31, 6'd0, 10'd63},
        {6'd3,  5'd2,  5'd23, 6'd0, 10'd55},
        {6'd32, 5'd31, 5'd20, 6'd0, 10'd516},
        {6'd32, 5'd10, 5'd9,  6'd0, 10'd169},
        {6'd6,  5'd5,  5'd8,  6'd0, 10'd88}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_n(input logic [5:0] v);
        cfg_we = 1'b1; cfg_nwin = v; tick(); cfg_we = 1'b0;
    endtask

    task automatic wr_cwp(input logic [4:0] v);
        cwp_we = 1'b1; cwp_wdata = v; tick(); cwp_we = 1'b0;
    endtask

    task automatic wr_mir(input logic [4:0] v);
        mir_we = 1'b1; mir_wdata = v; tick(); mir_we = 1'b0;
    endtask

    task automatic wr_wim(input logic [31:0] v);
        wim_we = 1'b1; wim_wdata = v; tick(); wim_we = 1'b0;
    endtask

    task automatic do_op(input logic s, input logic r, input logic f);
        save_req = s; restore_req = r; flush_req = f;
        tick();
        save_req = 1'b0; restore_req = 1'b0; flush_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 cwp", 32'(cwp_o), 0);
        chk("R1 wim", wim_o, 0);
        chk("R1 nwin", 32'(nwin_o), 8);
        chk("R1 flags", {30'd0, ovf, unf}, 0);
        chk("R1 mirror", 32'(cwp_mirror), 7);

        // R2 count writes
        @(posedge clk); #1;
        set_n(6'd2);  chk("R2 low ignored", 32'(nwin_o), 8);
        set_n(6'd33); chk("R2 high ignored", 32'(nwin_o), 8);
        wr_cwp(5'd3);
        set_n(6'd5);  chk("R2 accept", 32'(nwin_o), 5);
        chk("R2 clears cwp", 32'(cwp_o), 0);
        set_n(6'd32); chk("R2 max", 32'(nwin_o), 32);
        set_n(6'd3);  chk("R2 min", 32'(nwin_o), 3);

        // R3 and R4 lookup table
        for (int i = 0; i < 11; i++) begin
            logic [31:0] v;
            v = VEC[i];
            set_n(v[31:26]);
            wr_cwp(v[25:21]);
            lk_idx = v[20:16];
            #1;
            if (v[9:0] >= {v[31:26], 4'b0}) chk("R4 overhang row", 32'(lk_phys), 32'(v[9:0]));
            else                            chk("R3 modulo row", 32'(lk_phys), 32'(v[9:0]));
        end

        // R5 save without trap
        set_n(6'd8);
        do_op(1, 0, 0); chk("R5 wrap to top", 32'(cwp_o), 7);
        chk("R5 no ovf", 32'(ovf), 0);
        do_op(1, 0, 0); chk("R5 step", 32'(cwp_o), 6);

        // R13 spill and fill windows
        chk("R13 spill", 32'(spill_win), 4);
        chk("R13 fill", 32'(fill_win), 7);
        wr_cwp(5'd0);
        chk("R13 spill wrap", 32'(spill_win), 6);
        chk("R13 fill", 32'(fill_win), 1);
        wr_cwp(5'd7); chk("R13 fill wrap", 32'(fill_win), 0);
        wr_cwp(5'd1); chk("R13 spill wrap 1", 32'(spill_win), 7);

        // R6 save overflow
        set_n(6'd8);
        wr_wim(32'h80);
        do_op(1, 0, 0);
        chk("R6 ovf", 32'(ovf), 1);
        chk("R6 cwp held", 32'(cwp_o), 0);
        chk("R6 rotate", wim_o, 32'h40);
        tick(); chk("R6 ovf pulse", 32'(ovf), 0);
        do_op(1, 0, 0); chk("R6 then move", 32'(cwp_o), 7);
        do_op(1, 0, 0);
        chk("R6 second ovf", 32'(ovf), 1);
        chk("R6 second rotate", wim_o, 32'h20);
        set_n(6'd5); wr_cwp(5'd1); wr_wim(32'h1);
        do_op(1, 0, 0);
        chk("R6 ovf n5", 32'(ovf), 1);
        chk("R6 rotate wraps in count", wim_o, 32'h10);

        // R7 restore without trap
        set_n(6'd5); wr_cwp(5'd4);
        do_op(0, 1, 0); chk("R7 wrap to 0", 32'(cwp_o), 0);
        chk("R7 no unf", 32'(unf), 0);
        do_op(0, 1, 0); chk("R7 step", 32'(cwp_o), 1);

        // R8 restore underflow
        set_n(6'd5); wr_cwp(5'd4); wr_wim(32'h1);
        do_op(0, 1, 0);
        chk("R8 unf", 32'(unf), 1);
        chk("R8 cwp held", 32'(cwp_o), 4);
        chk("R8 rotate", wim_o, 32'h2);
        wr_cwp(5'd3); wr_wim(32'h10);
        do_op(0, 1, 0);
        chk("R8 unf 2", 32'(unf), 1);
        chk("R8 rotate wraps in count", wim_o, 32'h1);

        // R9 flush
        set_n(6'd8); wr_cwp(5'd2); wr_wim(32'h40);
        chk("R9 depth", 32'(flush_depth), 3);
        do_op(0, 0, 1);
        chk("R9 onehot", wim_o, 32'h08);
        chk("R9 cwp held", 32'(cwp_o), 2);
        chk("R9 depth after", 32'(flush_depth), 0);
        wr_cwp(5'd7);
        do_op(0, 0, 1); chk("R9 onehot wrap", wim_o, 32'h01);
        set_n(6'd8);   chk("R9 depth empty mask", 32'(flush_depth), 7);

        // R10 mirrored view
        wr_cwp(5'd2); chk("R10 read", 32'(cwp_mirror), 5);
        wr_mir(5'd3); chk("R10 write", 32'(cwp_o), 4);
        chk("R10 read back", 32'(cwp_mirror), 3);
        wr_mir(5'd9); chk("R10 out of range forced", 32'(cwp_o), 7);
        chk("R10 read zero", 32'(cwp_mirror), 0);

        // R11 ignored pointer write and masked mask write
        wr_cwp(5'd2);
        wr_cwp(5'd8);  chk("R11 cwp ignored", 32'(cwp_o), 2);
        wr_cwp(5'd31); chk("R11 cwp ignored 31", 32'(cwp_o), 2);
        set_n(6'd5);
        wr_wim(32'hFFFF_FFFF); chk("R11 wim masked", wim_o, 32'h1F);

        // R12 priority
        set_n(6'd8); wr_cwp(5'd3);
        do_op(1, 1, 0); chk("R12 save over restore", 32'(cwp_o), 2);
        do_op(1, 0, 1);
        chk("R12 flush over save cwp", 32'(cwp_o), 2);
        chk("R12 flush over save wim", wim_o, 32'h08);
        cfg_we = 1'b1; cfg_nwin = 6'd6; save_req = 1'b1;
        tick();
        cfg_we = 1'b0; save_req = 1'b0;
        chk("R12 cfg wins nwin", 32'(nwin_o), 6);
        chk("R12 cfg wins cwp", 32'(cwp_o), 0);
        chk("R12 cfg wins flag", 32'(ovf), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule